// File: doc/BRIEF.md
# Debug Module Control and Status Port

This block holds the run-control state of a debug module that serves one hart. A debugger reaches it through a simple request/response port carrying a 7-bit register address, a write flag and 32 bits of write data; every request is answered exactly one cycle later. The block decodes two registers. The control word holds the module-enable bit, the hart halt request and the request for a system reset that leaves the debug logic alone. The status word reports the hart's availability and a fixed version field.

The enable bit drives a module-active output. The halt bit drives the debug request toward the hart. The system-reset bit drives a reset request to the rest of the chip, and that request stays high until the debugger clears it. While the module is disabled, every write is dropped except its effect on the enable bit, and the control word reads as zero. Writing the enable bit to 0 returns all other state to its reset value. The block is reset only by its own `rst_n`, so its state survives the system reset it requests.

Top module: `dbg_ctrl_status`

## Requirements
- R1: After reset, `dm_active`, `halt_req`, `sys_reset_req` and `rsp_valid` are 0, and the control word (address 0x10) reads 0.
- R2: A write to address 0x10 with bit 0 set makes `dm_active` 1 from the cycle after the request. A write with bit 0 clear makes it 0.
- R3: While the module is active, a control write with bit 0 set loads bit 31 into `halt_req`. `halt_req` changes only on a control write.
- R4: While the module is active, a control write with bit 0 set loads bit 1 into `sys_reset_req`. The request stays high until a later control write clears it.
- R5: In the status word (address 0x11), bits 12 and 13 both equal the level of `hart_unavail` in the request cycle.
- R6: The status word always reads bits [3:0] = 2, bit 7 = 1, and every other bit except 12 and 13 = 0.
- R7: While `dm_active` is 0, a control write leaves `halt_req` and `sys_reset_req` at 0, whatever the write data.
- R8: A control write with bit 0 clear forces `halt_req` and `sys_reset_req` to 0.
- R9: While `sys_reset_req` is 1, the control state keeps its values and stays writable. After the reset request is cleared, the halt bit still reads back as it was written.
- R10: Each request cycle produces a one-cycle `rsp_valid` pulse in the next cycle. A read of the control word returns bit 0 = active, bit 1 = reset request and bit 31 = halt. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the debug logic |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| hart_unavail | input | 1 | Hart is unavailable (for example, held in reset) |
| dm_active | output | 1 | Debug module enabled |
| halt_req | output | 1 | Halt request to the hart |
| sys_reset_req | output | 1 | Reset request to the rest of the system |

## Verification
The assertions assume that `req_valid` is a single-cycle strobe with the address, write flag and data valid in the same cycle. They also assume that `hart_unavail` is a synchronous level that is stable across the clock edge at which a status read is sampled. The bench drives every input on the falling clock edge, holds each request for exactly one cycle, and changes `hart_unavail` only between requests. It sweeps all eight combinations of the three control bits, from both the disabled and the enabled state.

// File: rtl/dbg_cs_pkg.sv
package dbg_cs_pkg;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 7;
    localparam int BIT_ENABLE   = 0;
    localparam int BIT_SYSRST   = 1;
    localparam int BIT_HALT     = 31;
    localparam int BIT_UNAV_ALL = 12;
    localparam int BIT_UNAV_ANY = 13;
    localparam int BIT_AUTH     = 7;

    typedef struct packed {
        logic enable;
        logic halt;
        logic sysrst;
    } ctrl_state_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] rdata;
    } rsp_state_t;
endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
    import dbg_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_state_t       state_q
);
    ctrl_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (!wdata[BIT_ENABLE]) begin
                state_d = '0;
            end else if (!state_q.enable) begin
                state_d        = '0;
                state_d.enable = 1'b1;
            end else begin
                state_d.enable = 1'b1;
                state_d.halt   = wdata[BIT_HALT];
                state_d.sysrst = wdata[BIT_SYSRST];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/dbg_status_view.sv
module dbg_status_view
    import dbg_cs_pkg::*;
#(
    parameter int VERSION = 2,
    parameter int VER_W   = 4
) (
    input  logic              hart_unavail,
    input  ctrl_state_t       state,
    output logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] ctrl_word
);
    always_comb begin
        stat_word               = '0;
        stat_word[VER_W-1:0]    = VER_W'(VERSION);
        stat_word[BIT_AUTH]     = 1'b1;
        stat_word[BIT_UNAV_ALL] = hart_unavail;
        stat_word[BIT_UNAV_ANY] = hart_unavail;

        ctrl_word             = '0;
        ctrl_word[BIT_ENABLE] = state.enable;
        ctrl_word[BIT_SYSRST] = state.sysrst;
        ctrl_word[BIT_HALT]   = state.halt;
    end
endmodule

// File: rtl/dbg_rsp.sv
module dbg_rsp
    import dbg_cs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [DATA_W-1:0] stat_word,
    output rsp_state_t        rsp_q
);
    rsp_state_t rsp_d;

    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.rdata = '0;
        if (req_valid && !req_write) begin
            if (req_addr == CTRL_ADDR)      rsp_d.rdata = ctrl_word;
            else if (req_addr == STAT_ADDR) rsp_d.rdata = stat_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end
endmodule

// File: rtl/dbg_ctrl_status.sv
module dbg_ctrl_status
    import dbg_cs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h11,
    parameter int                VERSION   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              hart_unavail,
    output logic              dm_active,
    output logic              halt_req,
    output logic              sys_reset_req
);
    ctrl_state_t       ctrl_q;
    rsp_state_t        rsp_q;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] ctrl_word;
    logic              ctrl_wr;

    assign ctrl_wr = req_valid && req_write && (req_addr == CTRL_ADDR);

    dbg_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wdata  (req_wdata),
        .state_q(ctrl_q)
    );

    dbg_status_view #(.VERSION(VERSION)) u_view (
        .hart_unavail(hart_unavail),
        .state       (ctrl_q),
        .stat_word   (stat_word),
        .ctrl_word   (ctrl_word)
    );

    dbg_rsp #(.CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .ctrl_word(ctrl_word),
        .stat_word(stat_word),
        .rsp_q    (rsp_q)
    );

    assign rsp_valid     = rsp_q.valid;
    assign rsp_rdata     = rsp_q.rdata;
    assign dm_active     = ctrl_q.enable;
    assign halt_req      = ctrl_q.halt;
    assign sys_reset_req = ctrl_q.sysrst;
endmodule

// File: rtl/dbg_ctrl_status_chk.sv
module dbg_ctrl_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [6:0]  req_addr,
    input logic [31:0] req_wdata,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        hart_unavail,
    input logic        dm_active,
    input logic        halt_req,
    input logic        sys_reset_req
);
    logic cw;
    logic sr;
    assign cw = req_valid && req_write && (req_addr == 7'h10);
    assign sr = req_valid && !req_write && (req_addr == 7'h11);

    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_enable_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && req_wdata[0]) |=> dm_active);
    assert_halt_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cw |=> $stable(halt_req));
    assert_sysrst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset_req && !cw) |=> sys_reset_req);
    assert_unavail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sr |=> (rsp_rdata[12] == $past(hart_unavail)) && (rsp_rdata[13] == $past(hart_unavail)));
    assert_version_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr |=> (rsp_rdata[3:0] == 4'd2) && rsp_rdata[7]);
    assert_inactive_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dm_active && !halt_req && !sys_reset_req) |=> (!halt_req && !sys_reset_req));
    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && !req_wdata[0]) |=> (!dm_active && !halt_req && !sys_reset_req));
endmodule

bind dbg_ctrl_status dbg_ctrl_status_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .hart_unavail (hart_unavail),
    .dm_active    (dm_active),
    .halt_req     (halt_req),
    .sys_reset_req(sys_reset_req)
);

// File: tb/test_dbg_ctrl_status.sv
module test_dbg_ctrl_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        hart_unavail = 1'b0;
    logic        dm_active;
    logic        halt_req;
    logic        sys_reset_req;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbg_ctrl_status i_dbg_ctrl_status (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .hart_unavail(hart_unavail), .dm_active(dm_active),
        .halt_req(halt_req), .sys_reset_req(sys_reset_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [6:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 rsp_valid pulse", 32'(rsp_valid), 32'd1);
        rd = rsp_rdata;
    endtask

    function automatic logic [31:0] ctrl_pat(input logic en, input logic sr, input logic h);
        ctrl_pat = {h, 29'd0, sr, en};
    endfunction

    function automatic logic [31:0] stat_exp(input logic u);
        stat_exp = 32'h82 | ({18'd0, u, u, 12'd0});
    endfunction

    initial begin
        logic [31:0] rd;
        logic exp_en, exp_h, exp_s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dm_active", 32'(dm_active), 0);
        chk("R1 halt_req", 32'(halt_req), 0);
        chk("R1 sys_reset_req", 32'(sys_reset_req), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        do_req(1'b0, 7'h10, 0, rd);
        chk("R1 ctrl read", rd, 0);
        @(negedge clk);
        chk("R10 rsp_valid drops", 32'(rsp_valid), 0);

        // sweep: prior enable state x all control bit patterns
        for (int pa = 0; pa < 2; pa++) begin
            for (int w = 0; w < 8; w++) begin
                do_req(1'b1, 7'h10, 32'h0, rd);
                if (pa == 1) do_req(1'b1, 7'h10, 32'h1, rd);
                do_req(1'b1, 7'h10, ctrl_pat(w[0], w[1], w[2]), rd);
                exp_en = w[0];
                exp_h  = (pa == 1) && w[0] && w[2];
                exp_s  = (pa == 1) && w[0] && w[1];
                chk(w[0] ? "R2 enable set" : "R2 enable clear", 32'(dm_active), 32'(exp_en));
                chk(pa == 1 ? (w[0] ? "R3 halt load" : "R8 halt clear") : "R7 halt gated",
                    32'(halt_req), 32'(exp_h));
                chk(pa == 1 ? (w[0] ? "R4 sysrst load" : "R8 sysrst clear") : "R7 sysrst gated",
                    32'(sys_reset_req), 32'(exp_s));
                do_req(1'b0, 7'h10, 0, rd);
                chk("R10 ctrl readback", rd, ctrl_pat(exp_en, exp_s, exp_h));
            end
        end

        // status word with both unavailable levels, active and inactive
        for (int a = 0; a < 2; a++) begin
            do_req(1'b1, 7'h10, 32'(a), rd);
            for (int u = 0; u < 2; u++) begin
                hart_unavail = u[0];
                do_req(1'b0, 7'h11, 0, rd);
                chk("R5 R6 status word", rd, stat_exp(u[0]));
            end
        end
        hart_unavail = 1'b0;

        // unmapped reads and writes
        do_req(1'b0, 7'h12, 0, rd);
        chk("R10 unmapped read", rd, 0);
        do_req(1'b1, 7'h11, 32'hFFFF_FFFF, rd);
        chk("R10 write rdata", rd, 0);

        // state retained across the requested system reset
        do_req(1'b1, 7'h10, ctrl_pat(1, 1, 1), rd);
        chk("R4 sysrst asserted", 32'(sys_reset_req), 1);
        repeat (5) @(negedge clk);
        chk("R4 sysrst held", 32'(sys_reset_req), 1);
        hart_unavail = 1'b1;
        do_req(1'b0, 7'h11, 0, rd);
        chk("R5 unavail during reset", rd, stat_exp(1'b1));
        do_req(1'b0, 7'h10, 0, rd);
        chk("R9 ctrl during reset", rd, ctrl_pat(1, 1, 1));
        do_req(1'b1, 7'h10, ctrl_pat(1, 0, 1), rd);
        hart_unavail = 1'b0;
        chk("R9 sysrst released", 32'(sys_reset_req), 0);
        chk("R9 halt kept", 32'(halt_req), 1);
        do_req(1'b0, 7'h10, 0, rd);
        chk("R9 ctrl after reset", rd, ctrl_pat(1, 0, 1));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule